// File: doc/BRIEF.md
# Tick-Synchronised Register Write Port

This block is the host-facing write front end of a slow timekeeping peripheral. Its registers may only change on a once-per-second tick. A host write to one of the five delayed registers (time, enable, stopwatch, alarm, prescale) is not applied at once. It is captured in a single shadow entry, and a pending flag is raised. On the next tick the staged value is copied into its target register, the pending flag drops, and a complete flag rises.

While a write is pending, any further write to a delayed register is dropped without any error indication. Software is expected to poll the pending flag before it issues the next delayed write. The status register is exempt from this delay. Writing ones to it clears event bits and the complete flag in the same cycle. The event bits are set by the timekeeping logic through a set-pulse input. Reads always return committed register contents and never the staged value.

The write port follows valid/ready naming, but it never applies back-pressure. `wr_ready` is held high, and a write that cannot be staged is accepted and discarded rather than stalled. Reads are combinational on `rd_addr`.

Top module: `tick_sync_wr_port`

## Requirements
- R1: A delayed register (address 1 time, 2 enable, 3 stopwatch, 4 alarm, 5 prescale) changes only at a clock edge where `tick` is high and a write is pending. It then takes the staged data.
- R2: A write to a delayed register that is accepted sets pending (status bit 14) from the next cycle. Until the commit, reads of the target still return its old value.
- R3: A delayed-register write that arrives while pending is set is discarded, including in the very cycle of the committing tick. The shadow contents and all registers are left unchanged.
- R4: Pending clears in the same cycle that complete (status bit 15) sets. Complete stays set until the host clears it.
- R5: A status write (address 0) with bit 15 set clears complete at the next edge, unless a commit happens at that same edge. In that case complete stays set.
- R6: Status writes act at the next edge and never raise pending. Bits 13:0 are event bits: `evt_in` sets them, and a one written to a bit clears it. A set and a clear of the same bit in the same cycle leave it set.
- R7: Writes to addresses 6 and 7 have no effect. Reads of those addresses return zero.
- R8: `wr_ready` is always high. The port never stalls the host.
- R9: After reset, all registers, pending, complete and the event bits read zero.
- R10: A write accepted in a cycle where `tick` is high is not committed by that tick. It waits for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Always high; writes are never stalled |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | DATA_W | Write data |
| tick | input | 1 | One-cycle pulse from the slow time base |
| evt_in | input | 14 | Event set pulses for status bits 13:0 |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | DATA_W | Committed contents of the addressed register |

## Verification
Two pairs of functions can meet in one cycle. A committing tick can coincide with a host write that clears complete. An event set pulse can coincide with a host clear of the same event bit. The bench forces both pairs in directed cycles, and its random phase produces them freely. It expects complete and the event bit to end up set. A third collision is a new delayed write in the committing tick's cycle, which must be dropped. The behavioural model applies these priorities on every clock, and its result is compared with the read port.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int ADDR_STATUS  = 0;
  localparam int NUM_DELAYED  = 5;
  localparam int EVT_W        = 14;
  localparam int PEND_BIT     = 14;
  localparam int DONE_BIT     = 15;
  localparam int STAT_USED_W  = 16;
endpackage

// File: rtl/tsw_stage.sv
module tsw_stage #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              tick,
  input  logic              clr_done,
  output logic              pending,
  output logic              done,
  output logic              commit,
  output logic [IDX_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data
);
  logic              pend_q, done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  assign commit      = pend_q & tick;
  assign pending     = pend_q;
  assign done        = done_q;
  assign commit_idx  = idx_q;
  assign commit_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      idx_q  <= idx_in;
      data_q <= data_in;
    end else if (commit) begin
      pend_q <= 1'b0;
    end
  end

  // commit outranks a host clear landing on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (commit)   done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end
endmodule

// File: rtl/tsw_bank.sv
module tsw_bank #(
  parameter int DATA_W = 32,
  parameter int NUM    = 5,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [IDX_W-1:0]      commit_idx,
  input  logic [DATA_W-1:0]     commit_data,
  output logic [NUM*DATA_W-1:0] regs_flat
);
  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (commit && commit_idx == IDX_W'(g))
        r_q <= commit_data;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = r_q;
  end
endmodule

// File: rtl/tsw_evt.sv
module tsw_evt #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_in,
  input  logic [W-1:0] clr_in,
  output logic [W-1:0] bits
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~clr_in) | set_in;
  end
endmodule

// File: rtl/tick_sync_wr_port.sv
module tick_sync_wr_port
  import tsw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      tick,
  input  logic [tsw_pkg::EVT_W-1:0] evt_in,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int IDX_W = (NUM_DELAYED > 1) ? $clog2(NUM_DELAYED) : 1;

  logic              wr_stat, wr_dly, accept, clr_done;
  logic              pending_q, done_q, commit;
  logic [IDX_W-1:0]  wr_idx, rd_idx, commit_idx;
  logic [DATA_W-1:0] commit_data;
  logic [NUM_DELAYED*DATA_W-1:0] regs_flat;
  logic [EVT_W-1:0]  evt_bits, evt_clr;
  logic [DATA_W-1:0] status_word;

  assign wr_ready = 1'b1;
  assign wr_stat  = wr_valid && (wr_addr == ADDR_W'(ADDR_STATUS));
  assign wr_dly   = wr_valid && (wr_addr >= ADDR_W'(1)) &&
                    (wr_addr <= ADDR_W'(NUM_DELAYED));
  assign accept   = wr_dly && !pending_q;
  assign wr_idx   = IDX_W'(wr_addr - ADDR_W'(1));
  assign rd_idx   = IDX_W'(rd_addr - ADDR_W'(1));
  assign clr_done = wr_stat && wr_data[DONE_BIT];
  assign evt_clr  = wr_stat ? wr_data[EVT_W-1:0] : '0;

  tsw_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .accept(accept), .idx_in(wr_idx),
    .data_in(wr_data), .tick(tick), .clr_done(clr_done),
    .pending(pending_q), .done(done_q), .commit(commit),
    .commit_idx(commit_idx), .commit_data(commit_data)
  );

  tsw_bank #(.DATA_W(DATA_W), .NUM(NUM_DELAYED), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_idx(commit_idx),
    .commit_data(commit_data), .regs_flat(regs_flat)
  );

  tsw_evt #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_in(evt_in), .clr_in(evt_clr),
    .bits(evt_bits)
  );

  assign status_word = {{(DATA_W-STAT_USED_W){1'b0}}, done_q, pending_q, evt_bits};

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_STATUS))
      rd_data = status_word;
    else if (rd_addr <= ADDR_W'(NUM_DELAYED))
      rd_data = regs_flat[int'(rd_idx)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/tsw_chk.sv
module tsw_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int FLAT_W = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              accept,
  input logic              clr_done,
  input logic              pending_q,
  input logic              done_q,
  input logic [IDX_W-1:0]  commit_idx,
  input logic [DATA_W-1:0] commit_data,
  input logic [FLAT_W-1:0] regs_flat
);
  a_r2_pend_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pending_q);

  a_r3_shadow_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !tick) |=> ($stable(commit_data) && $stable(commit_idx)));

  a_r1_regs_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending_q && tick) |=> $stable(regs_flat));

  a_r4_pend_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending_q) |-> done_q);

  a_r5_commit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && tick && clr_done) |=> done_q);
endmodule

bind tick_sync_wr_port tsw_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .FLAT_W(tsw_pkg::NUM_DELAYED*DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .accept(accept),
  .clr_done(clr_done), .pending_q(pending_q), .done_q(done_q),
  .commit_idx(commit_idx), .commit_data(commit_data), .regs_flat(regs_flat)
);

// File: tb/tb_tick_sync_wr_port.sv
module tb_tick_sync_wr_port;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          tick = 1'b0;
  logic [13:0]   evt_in = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  tick_sync_wr_port #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick), .evt_in(evt_in),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference
  logic [DW-1:0] m_reg [1:5];
  logic          m_pend, m_done;
  int            m_sa;
  logic [DW-1:0] m_sd;
  logic [13:0]   m_evt;

  function automatic logic [DW-1:0] m_read(input int a);
    if (a == 0) return {16'h0, m_done, m_pend, m_evt};
    if (a >= 1 && a <= 5) return m_reg[a];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 5; i++) m_reg[i] = '0;
      m_pend = 0; m_done = 0; m_sa = 1; m_sd = '0; m_evt = '0;
    end else begin
      bit cm, acc, sw;
      cm  = tick && m_pend;
      sw  = wr_valid && (int'(wr_addr) == 0);
      acc = wr_valid && int'(wr_addr) >= 1 && int'(wr_addr) <= 5 && !m_pend;
      if (cm) m_reg[m_sa] = m_sd;
      if (cm) m_done = 1;
      else if (sw && wr_data[15]) m_done = 0;
      if (acc) begin m_pend = 1; m_sa = int'(wr_addr); m_sd = wr_data; end
      else if (cm) m_pend = 0;
      m_evt = (m_evt & ~(sw ? wr_data[13:0] : 14'h0)) | evt_in;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(int'(rd_addr) == 0 ? "R4/R6 status" : "R1 register", rd_data, m_read(int'(rd_addr)));
      chk("R8 ready", {31'h0, wr_ready}, 32'h1);
    end
  end

  task automatic cyc(input bit v, input int a, input logic [DW-1:0] d,
                     input bit t, input logic [13:0] e, input int ra);
    @(negedge clk); #2;
    wr_valid = v; wr_addr = AW'(a); wr_data = d; tick = t; evt_in = e; rd_addr = AW'(ra);
    @(negedge clk); #1;
    wr_valid = 0; tick = 0; evt_in = '0;
  endtask

  initial begin
    #400000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0); chk("R9 status reset", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 1); chk("R9 time reset", rd_data, 32'h0);
    cyc(1, 1, 32'h0001_2345, 0, 0, 0); chk("R2 pending set", rd_data, 32'h4000);
    cyc(0, 0, 0, 0, 0, 1); chk("R2 old value read", rd_data, 32'h0);
    cyc(1, 2, 32'h0000_AAAA, 0, 0, 0); chk("R3 dropped, still pending", rd_data, 32'h4000);
    cyc(0, 0, 0, 1, 0, 1); chk("R1 commit on tick", rd_data, 32'h0001_2345);
    cyc(0, 0, 0, 0, 0, 0); chk("R4 complete, not pending", rd_data, 32'h8000);
    cyc(0, 0, 0, 0, 0, 2); chk("R3 enable untouched", rd_data, 32'h0);
    cyc(1, 3, 32'h55, 0, 0, 0); chk("R4 complete holds", rd_data, 32'hC000);
    cyc(1, 0, 32'h8000, 1, 0, 0); chk("R5 commit beats clear", rd_data, 32'h8000);
    cyc(1, 0, 32'h8000, 0, 0, 0); chk("R5 clear complete", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 3); chk("R1 stopwatch value", rd_data, 32'h55);
    cyc(1, 6, 32'hFF, 0, 0, 0); chk("R7 unmapped write", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 6); chk("R7 unmapped read", rd_data, 32'h0);
    cyc(1, 4, 32'h99, 1, 0, 4); chk("R10 no commit same tick", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 0); chk("R10 pending after", rd_data, 32'h4000);
    cyc(0, 0, 0, 1, 0, 4); chk("R10 commit next tick", rd_data, 32'h99);
    cyc(1, 0, 32'h8000, 0, 0, 0);
    cyc(0, 0, 0, 0, 14'h0005, 0); chk("R6 event set", rd_data, 32'h0005);
    cyc(1, 0, 32'h0001, 0, 14'h0001, 0); chk("R6 set beats clear", rd_data, 32'h0005);
    cyc(1, 0, 32'h0004, 0, 0, 0); chk("R6 event clear", rd_data, 32'h0001);
    cyc(1, 5, 32'h7, 0, 0, 0);
    cyc(1, 0, 32'h0001, 0, 0, 0); chk("R6 status write while pending", rd_data, 32'h4000);
    cyc(1, 2, 32'h1, 1, 0, 2); chk("R3 write on commit tick dropped", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 5); chk("R1 prescale committed", rd_data, 32'h7);
    cyc(0, 0, 0, 0, 0, 0); chk("R4 idle status", rd_data, 32'h8000);

    for (int k = 0; k < 4000; k++) begin
      int a = $urandom_range(0, 7);
      logic [DW-1:0] d = $urandom;
      cyc($urandom_range(0, 1) == 1, a, d, $urandom_range(0, 7) == 0,
          ($urandom_range(0, 5) == 0) ? 14'($urandom) : 14'h0, $urandom_range(0, 7));
    end

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule